// File: doc/BRIEF.md
# Cascaded Pacer Clock Generator

This block builds a long-period pacer strobe out of a small bank of 16-bit counter channels. Two of the channels are chained: the first divides the system clock by one divisor, and each low pulse it produces clocks the second, which divides by a second divisor. The pacer output is the second stage's output. It falls once every `divisor1 * divisor2` clock cycles and stays low for one full first-stage period, which is `divisor1` cycles. A divisor value of 0 stands for 65536.

Software works out the two divisors and writes them into a pending pair. An update strobe copies the pending pair into the active pair. A start strobe names the two channels and runs a fixed programming sequence on a shared internal write path. The sequence sets both channels to rate-generator mode, loads the second stage's divisor low byte then high byte, and then loads the first stage's divisor the same way. The first stage therefore cannot expire before the second stage holds its count. A stop strobe parks both named channels in terminal-count mode. While the pacer runs, its two channels are locked against general-purpose host access.

Host access is a valid/ready command port. A command is taken on a clock edge where `host_valid_i` and `host_ready_o` are both high. `host_ready_o` is low while a programming sequence runs and during any cycle with a start or stop strobe, and the host must hold its command until it is taken. Each taken command gets exactly one response, with `host_done_o` high in the following cycle. A read returns the live count. A write loads a 16-bit count, low byte first. A mode command selects terminal-count or rate-generator operation.

Top module: `pacer_cascade`

## Requirements
- R1: With active divisors d1 and d2 on a valid channel pair, `pacer_o` falls once every d1*d2 clock cycles and, after each fall, stays low for exactly d1 cycles.
- R2: A start or stop strobe is rejected when the two channel indices are equal, when either index is NUM_CH or higher, or when a programming sequence is already running. A rejection pulses `cfg_rej_o` for one cycle, one cycle after the strobe, and leaves the pacer, the busy locks and the channels unchanged.
- R3: An accepted start runs six write steps in this order: the control word of the first stage, the control word of the second stage, then the second divisor's low and high bytes, then the first divisor's low and high bytes. `host_ready_o` is low for those six cycles.
- R4: An accepted stop takes two write steps that put both named channels into terminal-count mode, which drives their `ch_out_o` bits low. It releases the busy locks and forces `pacer_o` high.
- R5: Writes to the pending divisors (`div_sel_i`=0 for the first stage, 1 for the second) change nothing until `div_update_i`, which copies both into the active pair. A count or divisor of 0 counts as 65536.
- R6: A write, a mode command or a read aimed at a busy channel is refused (`host_refused_o`=1, `host_rdata_o`=0). A command aimed at a channel index of NUM_CH or higher, or using opcode 3, is also refused. A command aimed at a free channel is accepted.
- R7: Host opcodes are 0 read, 1 write and 2 mode, where mode bit 0 selects terminal count and 1 selects rate generator. A read returns the channel's current count, which falls by one each cycle. In terminal-count mode the output is low from the mode command, rises when the loaded count N runs out (N+3 cycles after the write is taken), stays high, and the count wraps past 0 to 65535.
- R8: Every command taken on a valid/ready edge produces `host_done_o` high in the next cycle only.
- R9: After reset every channel is in terminal-count mode with its output low and a count of 0, no channel is busy, both divisors are 0 (65536), `pacer_o` is high and `host_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the base clock of the first stage |
| rst_n | input | 1 | Active-low synchronous reset |
| div_wr_i | input | 1 | Write strobe for a pending divisor |
| div_sel_i | input | 1 | Pending divisor select: 0 first stage, 1 second stage |
| div_data_i | input | CNT_W | Divisor value (0 means 65536) |
| div_update_i | input | 1 | Copy pending divisors into the active pair |
| first_sel_i | input | CH_W | Channel index of the first stage |
| second_sel_i | input | CH_W | Channel index of the second stage |
| pacer_on_i | input | 1 | Start strobe |
| pacer_off_i | input | 1 | Stop strobe |
| cfg_rej_o | output | 1 | One-cycle pulse on a rejected strobe |
| pacer_o | output | 1 | Pacer output, low once per period |
| host_valid_i | input | 1 | Host command valid |
| host_ready_o | output | 1 | Host command ready |
| host_op_i | input | 2 | Host opcode: 0 read, 1 write, 2 mode |
| host_ch_i | input | CH_W | Target channel |
| host_data_i | input | CNT_W | Count to load on a write |
| host_mode_i | input | 1 | Mode for a mode command: 0 terminal count, 1 rate generator |
| host_done_o | output | 1 | Response strobe, one cycle after a taken command |
| host_refused_o | output | 1 | Response: the command was refused |
| host_rdata_o | output | CNT_W | Response: count returned by a read |
| ch_out_o | output | NUM_CH | Output of every channel |

## Verification
A wrong load order or a wrong active divisor shows up as a wrong period or a wrong low width on `pacer_o` within one or two periods, and that is at most a few dozen cycles for the divisors used here. A busy flag that is lost or set wrong shows up on the very next host response as a wrong refusal bit. A broken program sequencer shows up as a wrong number of cycles with `host_ready_o` low. A channel whose terminal-count or wrap state is wrong shows up on its `ch_out_o` bit within N+3 cycles of loading N, and on the next read.

// File: rtl/pacer_pkg.sv
`timescale 1ns/1ps
package pacer_pkg;
  typedef enum logic { CM_TERM = 1'b0, CM_RATE = 1'b1 } cmode_e;
  typedef enum logic [1:0] { HOP_READ = 2'd0, HOP_WRITE = 2'd1, HOP_MODE = 2'd2, HOP_RSVD = 2'd3 } hop_e;
  typedef enum logic [2:0] { JOB_IDLE, JOB_ON, JOB_OFF, JOB_HWR, JOB_HMODE } job_e;
endpackage

// File: rtl/pacer_chan.sv
`timescale 1ns/1ps
module pacer_chan import pacer_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             ctl_wr_i,
  input  cmode_e           mode_i,
  input  logic             byte_wr_i,
  input  logic [CNT_W/2-1:0] byte_i,
  output logic             out_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int HALF = CNT_W / 2;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  cmode_e            mode_q;
  logic [HALF-1:0]   lo_q;
  logic              hi_phase_q;
  logic [CNT_W-1:0]  reload_q;
  logic              load_pend_q;
  logic              armed_q;
  logic [CNT_W-1:0]  count_q;
  logic              out_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q      <= CM_TERM;
      lo_q        <= '0;
      hi_phase_q  <= 1'b0;
      reload_q    <= '0;
      load_pend_q <= 1'b0;
      armed_q     <= 1'b0;
      count_q     <= '0;
      out_q       <= 1'b0;
    end else if (ctl_wr_i) begin
      mode_q      <= mode_i;
      hi_phase_q  <= 1'b0;
      load_pend_q <= 1'b0;
      armed_q     <= 1'b0;
      out_q       <= (mode_i == CM_RATE);
    end else begin
      if (tick_i) begin
        if (load_pend_q) begin
          count_q     <= reload_q;
          load_pend_q <= 1'b0;
          armed_q     <= 1'b1;
          if (mode_q == CM_TERM) out_q <= 1'b0;
        end else if (armed_q) begin
          count_q <= count_q - ONE;
          if (mode_q == CM_RATE) begin
            if (count_q == TWO) out_q <= 1'b0;
            if (count_q == ONE) begin
              out_q   <= 1'b1;
              count_q <= reload_q;
            end
          end else if (count_q == ONE) begin
            out_q <= 1'b1;
          end
        end
      end
      if (byte_wr_i) begin
        if (!hi_phase_q) begin
          lo_q       <= byte_i;
          hi_phase_q <= 1'b1;
        end else begin
          reload_q    <= {byte_i, lo_q};
          hi_phase_q  <= 1'b0;
          load_pend_q <= 1'b1;
        end
      end
    end
  end

  assign out_o   = out_q;
  assign count_o = count_q;

  // R1: a rate-generator low phase lasts exactly one tick of this channel
  p_rate_low_one_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == CM_RATE && !out_q && tick_i && !ctl_wr_i && !load_pend_q) |=> out_q);

  // R7: once a terminal count has expired the output stays high until reloaded
  p_term_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == CM_TERM && out_q && !ctl_wr_i && !(tick_i && load_pend_q)) |=> out_q);
endmodule

// File: rtl/pacer_seq.sv
`timescale 1ns/1ps
module pacer_seq import pacer_pkg::*; #(
  parameter int CNT_W = 16,
  parameter int CH_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               on_go_i,
  input  logic               off_go_i,
  input  logic               host_go_i,
  input  logic               host_wr_i,
  input  logic [CH_W-1:0]    first_i,
  input  logic [CH_W-1:0]    second_i,
  input  logic [CH_W-1:0]    host_ch_i,
  input  logic [CNT_W-1:0]   div1_i,
  input  logic [CNT_W-1:0]   div2_i,
  input  logic [CNT_W-1:0]   host_data_i,
  input  cmode_e             host_mode_i,
  output logic               idle_o,
  output logic               bus_ctl_o,
  output logic               bus_byte_o,
  output logic [CH_W-1:0]    bus_ch_o,
  output cmode_e             bus_mode_o,
  output logic [CNT_W/2-1:0] bus_data_o
);
  localparam int HALF = CNT_W / 2;

  job_e              job_q;
  logic [2:0]        step_q;
  logic [2:0]        last_step;
  logic [CH_W-1:0]   cha_q, chb_q;
  logic [CNT_W-1:0]  da_q, db_q;
  cmode_e            mode_q;

  always_comb begin
    case (job_q)
      JOB_ON:           last_step = 3'd5;
      JOB_OFF, JOB_HWR: last_step = 3'd1;
      default:          last_step = 3'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      job_q  <= JOB_IDLE;
      step_q <= '0;
      cha_q  <= '0;
      chb_q  <= '0;
      da_q   <= '0;
      db_q   <= '0;
      mode_q <= CM_TERM;
    end else if (on_go_i || off_go_i) begin
      job_q  <= on_go_i ? JOB_ON : JOB_OFF;
      step_q <= '0;
      cha_q  <= first_i;
      chb_q  <= second_i;
      da_q   <= div1_i;
      db_q   <= div2_i;
    end else if (host_go_i) begin
      job_q  <= host_wr_i ? JOB_HWR : JOB_HMODE;
      step_q <= '0;
      cha_q  <= host_ch_i;
      da_q   <= host_data_i;
      mode_q <= host_mode_i;
    end else if (job_q != JOB_IDLE) begin
      if (step_q == last_step) begin
        job_q  <= JOB_IDLE;
        step_q <= '0;
      end else begin
        step_q <= step_q + 3'd1;
      end
    end
  end

  always_comb begin
    bus_ctl_o  = 1'b0;
    bus_byte_o = 1'b0;
    bus_ch_o   = cha_q;
    bus_mode_o = CM_TERM;
    bus_data_o = '0;
    case (job_q)
      JOB_ON: begin
        case (step_q)
          3'd0: begin bus_ctl_o = 1'b1; bus_mode_o = CM_RATE; end
          3'd1: begin bus_ctl_o = 1'b1; bus_mode_o = CM_RATE; bus_ch_o = chb_q; end
          3'd2: begin bus_byte_o = 1'b1; bus_ch_o = chb_q; bus_data_o = db_q[HALF-1:0]; end
          3'd3: begin bus_byte_o = 1'b1; bus_ch_o = chb_q; bus_data_o = db_q[CNT_W-1:HALF]; end
          3'd4: begin bus_byte_o = 1'b1; bus_data_o = da_q[HALF-1:0]; end
          default: begin bus_byte_o = 1'b1; bus_data_o = da_q[CNT_W-1:HALF]; end
        endcase
      end
      JOB_OFF: begin
        bus_ctl_o = 1'b1;
        if (step_q != 3'd0) bus_ch_o = chb_q;
      end
      JOB_HWR: begin
        bus_byte_o = 1'b1;
        bus_data_o = (step_q == 3'd0) ? da_q[HALF-1:0] : da_q[CNT_W-1:HALF];
      end
      JOB_HMODE: begin
        bus_ctl_o  = 1'b1;
        bus_mode_o = mode_q;
      end
      default: ;
    endcase
  end

  assign idle_o = (job_q == JOB_IDLE);

  // R3: the first stage's low byte goes out only after the second stage's high byte
  p_second_before_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (job_q == JOB_ON && step_q == 3'd4) |-> ($past(bus_byte_o) && $past(bus_ch_o) == chb_q));
endmodule

// File: rtl/pacer_cascade.sv
`timescale 1ns/1ps
module pacer_cascade import pacer_pkg::*; #(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 16,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              div_wr_i,
  input  logic              div_sel_i,
  input  logic [CNT_W-1:0]  div_data_i,
  input  logic              div_update_i,
  input  logic [CH_W-1:0]   first_sel_i,
  input  logic [CH_W-1:0]   second_sel_i,
  input  logic              pacer_on_i,
  input  logic              pacer_off_i,
  output logic              cfg_rej_o,
  output logic              pacer_o,
  input  logic              host_valid_i,
  output logic              host_ready_o,
  input  logic [1:0]        host_op_i,
  input  logic [CH_W-1:0]   host_ch_i,
  input  logic [CNT_W-1:0]  host_data_i,
  input  logic              host_mode_i,
  output logic              host_done_o,
  output logic              host_refused_o,
  output logic [CNT_W-1:0]  host_rdata_o,
  output logic [NUM_CH-1:0] ch_out_o
);
  localparam int NSLOT = 1 << CH_W;

  logic [CNT_W-1:0]  pend1_q, pend2_q, act1_q, act2_q;
  logic [NUM_CH-1:0] busy_q;
  logic              act_q;
  logic [CH_W-1:0]   fst_q, snd_q;
  logic              seq_idle;
  logic              sel_ok, on_go, off_go;
  logic              host_acc, host_ok, host_go;
  logic [NSLOT-1:0]  busy_ext, out_ext;
  logic [NUM_CH-1:0] chan_out, chan_tick, chan_ctl, chan_byte;
  logic [CNT_W-1:0]  chan_cnt [NUM_CH];
  logic [CNT_W-1:0]  rd_sel;
  logic              bus_ctl, bus_byte;
  logic [CH_W-1:0]   bus_ch;
  cmode_e            bus_mode;
  logic [CNT_W/2-1:0] bus_data;

  assign sel_ok = ({1'b0, first_sel_i}  < (CH_W+1)'(NUM_CH)) &&
                  ({1'b0, second_sel_i} < (CH_W+1)'(NUM_CH)) &&
                  (first_sel_i != second_sel_i);
  assign on_go  = pacer_on_i && seq_idle && sel_ok;
  assign off_go = pacer_off_i && !pacer_on_i && seq_idle && sel_ok;

  assign busy_ext = NSLOT'(busy_q);
  assign out_ext  = NSLOT'(chan_out);

  assign host_ready_o = seq_idle && !pacer_on_i && !pacer_off_i;
  assign host_acc     = host_valid_i && host_ready_o;
  assign host_ok      = ({1'b0, host_ch_i} < (CH_W+1)'(NUM_CH)) && !busy_ext[host_ch_i] &&
                        (host_op_i != HOP_RSVD);
  assign host_go      = host_acc && host_ok && (host_op_i != HOP_READ);

  always_comb begin
    rd_sel = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (host_ch_i == CH_W'(c)) rd_sel = chan_cnt[c];
  end

  // divisor double buffer
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend1_q <= '0;
      pend2_q <= '0;
      act1_q  <= '0;
      act2_q  <= '0;
    end else begin
      if (div_wr_i && !div_sel_i) pend1_q <= div_data_i;
      if (div_wr_i &&  div_sel_i) pend2_q <= div_data_i;
      if (div_update_i) begin
        act1_q <= pend1_q;
        act2_q <= pend2_q;
      end
    end
  end

  // pacer ownership and host responses
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q         <= '0;
      act_q          <= 1'b0;
      fst_q          <= '0;
      snd_q          <= '0;
      cfg_rej_o      <= 1'b0;
      host_done_o    <= 1'b0;
      host_refused_o <= 1'b0;
      host_rdata_o   <= '0;
    end else begin
      cfg_rej_o <= (pacer_on_i || pacer_off_i) && !(sel_ok && seq_idle);
      if (on_go) begin
        act_q <= 1'b1;
        fst_q <= first_sel_i;
        snd_q <= second_sel_i;
        for (int c = 0; c < NUM_CH; c++)
          busy_q[c] <= (first_sel_i == CH_W'(c)) || (second_sel_i == CH_W'(c));
      end else if (off_go) begin
        act_q  <= 1'b0;
        busy_q <= '0;
      end
      host_done_o    <= host_acc;
      host_refused_o <= host_acc && !host_ok;
      host_rdata_o   <= (host_acc && host_ok && host_op_i == HOP_READ) ? rd_sel : '0;
    end
  end

  pacer_seq #(.CNT_W(CNT_W), .CH_W(CH_W)) seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .on_go_i     (on_go),
    .off_go_i    (off_go),
    .host_go_i   (host_go),
    .host_wr_i   (host_op_i == HOP_WRITE),
    .first_i     (first_sel_i),
    .second_i    (second_sel_i),
    .host_ch_i   (host_ch_i),
    .div1_i      (act1_q),
    .div2_i      (act2_q),
    .host_data_i (host_data_i),
    .host_mode_i (cmode_e'(host_mode_i)),
    .idle_o      (seq_idle),
    .bus_ctl_o   (bus_ctl),
    .bus_byte_o  (bus_byte),
    .bus_ch_o    (bus_ch),
    .bus_mode_o  (bus_mode),
    .bus_data_o  (bus_data)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    assign chan_tick[c] = (act_q && snd_q == CH_W'(c)) ? ~out_ext[fst_q] : 1'b1;
    assign chan_ctl[c]  = bus_ctl  && (bus_ch == CH_W'(c));
    assign chan_byte[c] = bus_byte && (bus_ch == CH_W'(c));
    pacer_chan #(.CNT_W(CNT_W)) chan_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (chan_tick[c]),
      .ctl_wr_i  (chan_ctl[c]),
      .mode_i    (bus_mode),
      .byte_wr_i (chan_byte[c]),
      .byte_i    (bus_data),
      .out_o     (chan_out[c]),
      .count_o   (chan_cnt[c])
    );
  end

  assign pacer_o  = act_q ? out_ext[snd_q] : 1'b1;
  assign ch_out_o = chan_out;

  // R2: a running pacer always owns two distinct, existing channels
  p_pair_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |-> (fst_q != snd_q && {1'b0, fst_q} < (CH_W+1)'(NUM_CH) &&
               {1'b0, snd_q} < (CH_W+1)'(NUM_CH)));

  // R2: a rejected strobe leaves ownership untouched
  p_reject_noop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rej_o |-> ($stable(busy_q) && $stable(act_q)));

  // R5: active divisors move only on an update strobe
  p_active_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !div_update_i |=> ($stable(act1_q) && $stable(act2_q)));

  // R6: a command on a locked channel is answered with a refusal
  p_busy_refuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_acc && busy_ext[host_ch_i]) |=> (host_done_o && host_refused_o));

  // R8: no response without a taken command
  p_done_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_done_o |-> $past(host_acc));
endmodule

// File: tb/pacer_cascade_tb_top.sv
`timescale 1ns/1ps
module pacer_cascade_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic div_wr = 0, div_sel = 0, div_upd = 0;
  logic [15:0] div_data = '0;
  logic [1:0] fsel = '0, ssel = '0;
  logic p_on = 0, p_off = 0;
  logic cfg_rej, pacer;
  logic h_valid = 0, h_ready, h_mode = 0;
  logic [1:0] h_op = '0, h_ch = '0;
  logic [15:0] h_data = '0;
  logic h_done, h_ref;
  logic [15:0] h_rdata;
  logic [2:0] ch_out;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  pacer_cascade dut_i (
    .clk(clk), .rst_n(rst_n),
    .div_wr_i(div_wr), .div_sel_i(div_sel), .div_data_i(div_data), .div_update_i(div_upd),
    .first_sel_i(fsel), .second_sel_i(ssel), .pacer_on_i(p_on), .pacer_off_i(p_off),
    .cfg_rej_o(cfg_rej), .pacer_o(pacer),
    .host_valid_i(h_valid), .host_ready_o(h_ready), .host_op_i(h_op), .host_ch_i(h_ch),
    .host_data_i(h_data), .host_mode_i(h_mode),
    .host_done_o(h_done), .host_refused_o(h_ref), .host_rdata_o(h_rdata),
    .ch_out_o(ch_out)
  );

  localparam int NV = 4;
  localparam int VF[NV]   = '{0, 1, 2, 0};
  localparam int VS[NV]   = '{1, 0, 1, 1};
  localparam int VD1[NV]  = '{3, 2, 5, 7};
  localparam int VD2[NV]  = '{4, 2, 3, 2};
  localparam int VPER[NV] = '{12, 4, 15, 14};

  task automatic chk(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got=%0d expected=%0d", tag, got, exp);
    end
  endtask

  task automatic set_div(input int d1, input int d2, input bit upd);
    @(negedge clk); div_wr = 1; div_sel = 0; div_data = 16'(d1);
    @(negedge clk); div_sel = 1; div_data = 16'(d2);
    @(negedge clk); div_wr = 0; div_upd = upd;
    @(negedge clk); div_upd = 0;
  endtask

  // strobe start (on=1) or stop; returns rejection flag and ready-low cycle count
  task automatic pacer_cmd(input bit on, input int f, input int s, output logic rej, output int busy_n);
    @(negedge clk); fsel = 2'(f); ssel = 2'(s); p_on = on; p_off = !on;
    @(negedge clk); p_on = 0; p_off = 0; rej = cfg_rej;
    busy_n = 0;
    while (!h_ready && busy_n < 20) begin busy_n++; @(negedge clk); end
    repeat (2) @(negedge clk);
  endtask

  task automatic host(input int op, input int ch, input int d, input bit m,
                      output logic rf, output logic [15:0] rd, output logic dn);
    @(negedge clk);
    while (!h_ready) @(negedge clk);
    h_valid = 1; h_op = 2'(op); h_ch = 2'(ch); h_data = 16'(d); h_mode = m;
    @(negedge clk); h_valid = 0;
    rf = h_ref; rd = h_rdata; dn = h_done;
  endtask

  task automatic wait_lvl(input logic lvl, output int n);
    n = 0;
    while (pacer !== lvl && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic measure(output int per, output int wid);
    int x, lo_n, hi_n;
    wait_lvl(1'b1, x);
    wait_lvl(1'b0, x);
    wait_lvl(1'b1, lo_n);
    wait_lvl(1'b0, hi_n);
    per = lo_n + hi_n;
    wid = lo_n;
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got=hang expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic rj, rf, dn;
    logic [15:0] rd, r1, r2;
    int nb, per, wid;

    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 reset state
    chk("R9 pacer_o after reset", pacer, 1);
    chk("R9 ch_out_o after reset", ch_out, 0);
    chk("R9 host_ready_o after reset", h_ready, 1);
    host(0, 0, 0, 0, rf, rd, dn);
    chk("R8 done after read", dn, 1);
    chk("R9 read ch0 not refused", rf, 0);
    chk("R9 ch0 count after reset", rd, 0);
    @(negedge clk);
    chk("R8 done is a single cycle", h_done, 0);

    // R1 vector walk over pairs and divisors
    for (int v = 0; v < NV; v++) begin
      set_div(VD1[v], VD2[v], 1'b1);
      pacer_cmd(1'b1, VF[v], VS[v], rj, nb);
      chk($sformatf("R2 valid pair %0d accepted", v), rj, 0);
      if (v == 0) chk("R3 ready low during start program", nb, 6);
      measure(per, wid);
      chk($sformatf("R1 period vector %0d", v), per, VPER[v]);
      chk($sformatf("R1 low width vector %0d", v), wid, VD1[v]);
    end

    // R5 pending divisors without update leave the period unchanged
    set_div(5, 2, 1'b0);
    pacer_cmd(1'b1, 0, 1, rj, nb);
    measure(per, wid);
    chk("R5 pending not applied before update", per, 14);
    set_div(5, 2, 1'b1);
    pacer_cmd(1'b1, 0, 1, rj, nb);
    measure(per, wid);
    chk("R5 period after update", per, 10);

    // R6 busy locks on channels 0 and 1
    host(1, 0, 99, 0, rf, rd, dn);
    chk("R6 write to busy ch0 refused", rf, 1);
    host(2, 1, 0, 0, rf, rd, dn);
    chk("R6 mode on busy ch1 refused", rf, 1);
    host(0, 1, 0, 0, rf, rd, dn);
    chk("R6 read busy ch1 refused", rf, 1);
    chk("R6 refused read data zero", rd, 0);
    host(0, 2, 0, 0, rf, rd, dn);
    chk("R6 read free ch2 accepted", rf, 0);
    host(3, 2, 0, 0, rf, rd, dn);
    chk("R6 reserved opcode refused", rf, 1);
    host(0, 3, 0, 0, rf, rd, dn);
    chk("R6 channel 3 refused", rf, 1);
    measure(per, wid);
    chk("R6 refused write left pacer period", per, 10);

    // R2 rejection while running
    pacer_cmd(1'b1, 1, 1, rj, nb);
    chk("R2 equal pair rejected", rj, 1);
    host(1, 0, 5, 0, rf, rd, dn);
    chk("R2 busy kept after rejection", rf, 1);
    measure(per, wid);
    chk("R2 pacer unchanged after rejection", per, 10);

    // R4 stop
    pacer_cmd(1'b0, 0, 1, rj, nb);
    chk("R4 stop accepted", rj, 0);
    chk("R4 stop program length", nb, 2);
    chk("R4 pacer_o high after stop", pacer, 1);
    chk("R4 channel outputs parked low", ch_out[1:0], 0);
    host(0, 0, 0, 0, rf, rd, dn);
    chk("R4 ch0 released", rf, 0);

    // R2 out-of-range pair while idle
    pacer_cmd(1'b1, 3, 0, rj, nb);
    chk("R2 out-of-range pair rejected", rj, 1);
    chk("R2 pacer_o stays high", pacer, 1);
    host(1, 1, 50, 0, rf, rd, dn);
    chk("R2 ch1 not locked after rejection", rf, 0);

    // R7 terminal count on ch2
    host(2, 2, 0, 0, rf, rd, dn);
    repeat (3) @(negedge clk);
    chk("R7 mode command drives output low", ch_out[2], 0);
    host(1, 2, 20, 0, rf, rd, dn);
    repeat (18) @(negedge clk);
    chk("R7 output low before expiry", ch_out[2], 0);
    repeat (6) @(negedge clk);
    chk("R7 output high after expiry", ch_out[2], 1);
    repeat (10) @(negedge clk);
    chk("R7 output stays high", ch_out[2], 1);
    host(0, 2, 0, 0, rf, rd, dn);
    chk("R7 count wrapped past zero", rd > 16'hFF00, 1);

    // R5 count 0 means 65536
    host(1, 2, 0, 0, rf, rd, dn);
    repeat (10) @(negedge clk);
    host(0, 2, 0, 0, rf, rd, dn);
    chk("R5 zero count runs from 65536", rd > 16'hFF00, 1);
    chk("R5 zero count not expired", ch_out[2], 0);

    // R7 live count falls one per cycle
    host(2, 2, 0, 1, rf, rd, dn);
    host(1, 2, 1000, 0, rf, rd, dn);
    repeat (5) @(negedge clk);
    host(0, 2, 0, 0, rf, r1, dn);
    host(0, 2, 0, 0, rf, r2, dn);
    chk("R7 count decrements per cycle", r1 - r2, 2);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule